// File: doc/BRIEF.md
# Multichannel DAC Register Update Controller

This block holds the digital register file of a four-channel, double-buffered DAC. Each channel has a 16-bit staging (input) register and a 12-bit output register that drives the converter. A decoded 24-bit command word arrives with a one-cycle valid strobe. Depending on the command, it writes staging registers, transfers staged values to the outputs, or loads a 4-bit per-channel update mask.

Each output register changes in one of three ways. A command can transfer it directly. A channel whose mask bit is set updates as soon as new data reaches its staging register. All other channels wait for an active-low load strobe pin, which passes through a two-flop synchronizer. While the synchronized strobe is low, every output register follows its staging register on every cycle. A system can therefore preload several channels and then change them together with one strobe pulse, while chosen channels keep updating without waiting.

Command word layout: bits [23:22] are don't-care, bits [21:19] hold the command, bits [18:16] hold the address and bits [15:0] hold the data. Output registers take data bits [15:4], left-justified.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset, every staging register, every output register and all four mask bits are zero.
- R2: Command 000 with address 000 to 011 (channels A to D) writes all 16 data bits into that channel's staging register only. If that channel's mask bit is 0 and the strobe is inactive, its output register is left unchanged.
- R3: Address 111 selects all four channels together. Addresses 100, 101 and 110 select no channel, so commands 000, 001 and 011 sent with them change no register.
- R4: Command 001 copies staging bits [15:4] of the addressed channel(s) into the output register on the same clock edge that captures the command.
- R5: Command 011 writes the staging register and loads the output register with data bits [15:4], both on the same edge.
- R6: Command 110 loads the mask from data bits [3:0], with bit 0 for channel A, bit 1 for B, bit 2 for C and bit 3 for D. The address field and data bits [15:4] are ignored.
- R7: For a channel whose mask bit is 1, command 000 also loads data bits [15:4] into its output register on the same edge, whatever the strobe level.
- R8: The load strobe pin takes effect on the third rising edge after it changes. On every edge where the synchronized strobe is low, each output register is loaded from its staging register bits [15:4]. A staging write made in such a cycle reaches the output on that same edge.
- R9: Commands 010, 100, 101 and 111, and any cycle with the valid strobe low, change no staging or mask register. Bits [23:22] of the word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word valid for this cycle |
| cmd_word | input | 24 | Decoded command word |
| load_n | input | 1 | Asynchronous active-low load strobe pin |
| mask_o | output | 4 | Per-channel immediate-update mask, bit 0 = channel A |
| stage_o | output | 64 | Staging registers, channel A in bits [15:0] |
| dac_o | output | 48 | Output registers, channel A in bits [11:0] |

## Verification
The assertions assume that the load strobe is high through reset and for at least two cycles afterwards, because the synchronizer stages reset to the inactive level. They also assume that a command word is only meaningful while the valid strobe is high. The stimulus keeps the strobe high except in dedicated phases. There it changes only at the falling clock edge, and it is held for at least three edges before the outputs are compared. This makes the two-cycle synchronizer delay deterministic. The command sweeps cover every command and address code against two different mask settings, with the strobe inactive.

// File: rtl/dacu_pkg.sv
package dacu_pkg;
    localparam int CMD_W  = 3;
    localparam int ADDR_W = 3;
    localparam int PAD_W  = 2;

    localparam logic [CMD_W-1:0] OP_WR_STAGE = 3'b000;
    localparam logic [CMD_W-1:0] OP_XFER     = 3'b001;
    localparam logic [CMD_W-1:0] OP_WR_XFER  = 3'b011;
    localparam logic [CMD_W-1:0] OP_MASK     = 3'b110;

    localparam logic [ADDR_W-1:0] ADDR_ALL = 3'b111;
endpackage

// File: rtl/dacu_cmd_decode.sv
module dacu_cmd_decode
    import dacu_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 16,
    localparam int WORD_W = PAD_W + CMD_W + ADDR_W + DATA_W
) (
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    output logic [NUM_CH-1:0] wr_sel,
    output logic [NUM_CH-1:0] xfer_sel,
    output logic              direct,
    output logic              mask_ld,
    output logic [DATA_W-1:0] data
);
    logic [CMD_W-1:0]  op;
    logic [ADDR_W-1:0] addr;
    logic [NUM_CH-1:0] hit;
    logic              is_wr, is_xfer, is_wrx;

    assign op   = cmd_word[DATA_W+ADDR_W +: CMD_W];
    assign addr = cmd_word[DATA_W +: ADDR_W];
    assign data = cmd_word[DATA_W-1:0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
        assign hit[c] = (addr == ADDR_ALL) || (addr == ADDR_W'(c));
    end

    always_comb begin
        is_wr   = cmd_valid && (op == OP_WR_STAGE);
        is_xfer = cmd_valid && (op == OP_XFER);
        is_wrx  = cmd_valid && (op == OP_WR_XFER);
        mask_ld = cmd_valid && (op == OP_MASK);
        direct  = is_wrx;
        wr_sel   = (is_wr || is_wrx) ? hit : '0;
        xfer_sel = is_xfer ? hit : '0;
    end
endmodule

// File: rtl/dacu_sync.sv
module dacu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.pipe = {sync_q.pipe[STAGES-2:0], async_n};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '{pipe: '1};
        else        sync_q <= sync_d;
    end

    assign sync_n = sync_q.pipe[STAGES-1];
endmodule

// File: rtl/dacu_channel.sv
module dacu_channel #(
    parameter int DATA_W = 16,
    parameter int OUT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              xfer,
    input  logic              direct,
    input  logic              mask_bit,
    input  logic              strobe_low,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] stage_o,
    output logic [OUT_W-1:0]  dac_o
);
    typedef struct packed {
        logic [DATA_W-1:0] stage;
        logic [OUT_W-1:0]  dac;
    } chan_t;

    chan_t ch_d, ch_q;
    logic  pass_through;

    always_comb begin
        ch_d = ch_q;
        pass_through = direct || mask_bit || strobe_low;
        if (wr) ch_d.stage = data;
        if (wr && pass_through)
            ch_d.dac = data[DATA_W-1 -: OUT_W];
        else if (xfer || strobe_low)
            ch_d.dac = ch_q.stage[DATA_W-1 -: OUT_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign stage_o = ch_q.stage;
    assign dac_o   = ch_q.dac;
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
    import dacu_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int DATA_W      = 16,
    parameter int OUT_W       = 12,
    parameter int SYNC_STAGES = 2,
    localparam int WORD_W = PAD_W + CMD_W + ADDR_W + DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [WORD_W-1:0]        cmd_word,
    input  logic                     load_n,
    output logic [NUM_CH-1:0]        mask_o,
    output logic [NUM_CH*DATA_W-1:0] stage_o,
    output logic [NUM_CH*OUT_W-1:0]  dac_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] mask;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [NUM_CH-1:0] wr_sel, xfer_sel;
    logic              direct, mask_ld, load_sync_n;
    logic [DATA_W-1:0] data;

    dacu_cmd_decode #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dec_i (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .wr_sel    (wr_sel),
        .xfer_sel  (xfer_sel),
        .direct    (direct),
        .mask_ld   (mask_ld),
        .data      (data)
    );

    dacu_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (load_n),
        .sync_n  (load_sync_n)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (mask_ld) ctrl_d.mask = data[NUM_CH-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign mask_o = ctrl_q.mask;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dacu_channel #(.DATA_W(DATA_W), .OUT_W(OUT_W)) ch_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr         (wr_sel[c]),
            .xfer       (xfer_sel[c]),
            .direct     (direct),
            .mask_bit   (ctrl_q.mask[c]),
            .strobe_low (!load_sync_n),
            .data       (data),
            .stage_o    (stage_o[c*DATA_W +: DATA_W]),
            .dac_o      (dac_o[c*OUT_W +: OUT_W])
        );
    end
endmodule

// File: rtl/dacu_update_chk.sv
module dacu_update_chk #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 16,
    parameter int OUT_W  = 12,
    localparam int WORD_W = DATA_W + 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cmd_valid,
    input logic [WORD_W-1:0]        cmd_word,
    input logic                     load_n,
    input logic [NUM_CH-1:0]        mask_o,
    input logic [NUM_CH*DATA_W-1:0] stage_o,
    input logic [NUM_CH*OUT_W-1:0]  dac_o
);
    logic [2:0] op, addr;
    assign op   = cmd_word[DATA_W+3 +: 3];
    assign addr = cmd_word[DATA_W +: 3];

    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == 3'b110) |=> mask_o == $past(cmd_word[NUM_CH-1:0]));

    // R9
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && op == 3'b110) |=> $stable(mask_o));

    // R9
    stage_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(stage_o));

    // R5
    write_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == 3'b011 && addr == 3'b000) |=>
        (dac_o[OUT_W-1:0] == $past(cmd_word[DATA_W-1 -: OUT_W]) &&
         stage_o[DATA_W-1:0] == $past(cmd_word[DATA_W-1:0])));

    // R7
    mask_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == 3'b000 && addr == 3'b000 && mask_o[0]) |=>
        dac_o[OUT_W-1:0] == $past(cmd_word[DATA_W-1 -: OUT_W]));

    // R8
    strobe_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load_n, 2) && !cmd_valid) |=>
        dac_o[OUT_W-1:0] == $past(stage_o[DATA_W-1 -: OUT_W]));

    // R2
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load_n, 2) && !cmd_valid) |=> $stable(dac_o));
endmodule

bind dac_update_ctrl dacu_update_chk #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .OUT_W(OUT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .load_n    (load_n),
    .mask_o    (mask_o),
    .stage_o   (stage_o),
    .dac_o     (dac_o)
);

// File: tb/dac_update_ctrl_tb.sv
module dac_update_ctrl_tb_top;
    localparam int NCH = 4;
    localparam int DW  = 16;
    localparam int OW  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [23:0]       cmd_word = '0;
    logic              load_n = 1'b1;
    logic [NCH-1:0]    mask_o;
    logic [NCH*DW-1:0] stage_o;
    logic [NCH*OW-1:0] dac_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [DW-1:0] m_stage [NCH];
    logic [OW-1:0] m_dac [NCH];
    logic [NCH-1:0] m_mask;
    logic           m_pin;

    always #2 clk = ~clk;

    dac_update_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .load_n(load_n), .mask_o(mask_o), .stage_o(stage_o), .dac_o(dac_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check_all(input string tag);
        n_chk++;
        if (mask_o !== m_mask) begin
            n_bad++;
            $display("FAIL %s mask: got %h expected %h", tag, mask_o, m_mask);
        end
        for (int c = 0; c < NCH; c++) begin
            n_chk++;
            if (stage_o[c*DW +: DW] !== m_stage[c] || dac_o[c*OW +: OW] !== m_dac[c]) begin
                n_bad++;
                $display("FAIL %s ch%0d: got stage %h dac %h expected stage %h dac %h",
                         tag, c, stage_o[c*DW +: DW], dac_o[c*OW +: OW], m_stage[c], m_dac[c]);
            end
        end
    endtask

    // Expected behaviour from the requirements (R2..R9).
    task automatic model(input logic [2:0] op, input logic [2:0] ad, input logic [15:0] d);
        logic [DW-1:0] old_stage [NCH];
        for (int c = 0; c < NCH; c++) old_stage[c] = m_stage[c];
        for (int c = 0; c < NCH; c++) begin
            logic sel, wr, xf;
            sel = (ad == 3'd7) || (ad == 3'(c));
            wr  = sel && (op == 3'b000 || op == 3'b011);
            xf  = sel && (op == 3'b001);
            if (wr) m_stage[c] = d;
            if (wr && (op == 3'b011 || m_mask[c] || m_pin)) m_dac[c] = d[15:4];
            else if (xf || m_pin) m_dac[c] = old_stage[c][15:4];
        end
        if (op == 3'b110) m_mask = d[3:0];
    endtask

    function automatic string tag_of(input logic [2:0] op, input logic [2:0] ad);
        if (op == 3'b110) return "R6";
        if (op == 3'b010 || op >= 3'b100) return "R9";
        if (ad >= 3'd4 && ad != 3'd7) return "R3";
        if (op == 3'b001) return "R4";
        if (op == 3'b011) return "R5";
        if (m_mask != 0) return "R7";
        return "R2";
    endfunction

    task automatic apply(input logic [1:0] pad, input logic [2:0] op,
                         input logic [2:0] ad, input logic [15:0] d, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = {pad, op, ad, d};
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = {~pad, ~op, ~ad, ~d};
        model(op, ad, d);
        check_all(tag);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin m_stage[c] = '0; m_dac[c] = '0; end
        m_mask = '0;
        m_pin  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R1");

        // Sweep every command and address under two mask settings.
        for (int mp = 0; mp < 2; mp++) begin
            logic [3:0] mv;
            mv = (mp == 0) ? 4'b0000 : 4'b0101;
            apply(2'b11, 3'b110, 3'd5, {12'hABC, mv}, "R6");
            for (int op = 0; op < 8; op++) begin
                for (int ad = 0; ad < 8; ad++) begin
                    logic [15:0] d;
                    d = 16'(op * 16'h2310 + ad * 16'h0471 + mp * 16'h8000 + 16'h0035);
                    if (op == 6) d[3:0] = mv;
                    apply(2'(op + ad), 3'(op), 3'(ad), d, tag_of(3'(op), 3'(ad)));
                end
            end
        end

        // Idle cycles with a garbage word: nothing changes.
        @(negedge clk);
        cmd_word = 24'hFFFFFF;
        repeat (4) @(negedge clk);
        check_all("R9");

        // Mask cleared, fresh staging values, outputs held.
        apply(2'b00, 3'b110, 3'd0, 16'h0000, "R6");
        for (int c = 0; c < NCH; c++)
            apply(2'b01, 3'b000, 3'(c), 16'(16'h1111 * (c + 5)), "R2");

        // Strobe low: takes effect on the third edge.
        @(negedge clk);
        load_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_all("R8");
        @(negedge clk);
        for (int c = 0; c < NCH; c++) m_dac[c] = m_stage[c][15:4];
        m_pin = 1'b1;
        check_all("R8");
        for (int c = 0; c < NCH; c++)
            apply(2'b10, 3'b000, 3'(c), 16'(16'h0F0F + c * 16'h1234), "R8");

        // Release strobe, then staged writes must wait.
        @(negedge clk);
        load_n = 1'b1;
        repeat (3) @(negedge clk);
        m_pin = 1'b0;
        check_all("R8");
        apply(2'b00, 3'b000, 3'd7, 16'hC3A5, "R2");
        apply(2'b00, 3'b001, 3'd2, 16'h0000, "R4");
        apply(2'b00, 3'b110, 3'd7, 16'hFFF8, "R6");
        apply(2'b00, 3'b000, 3'd3, 16'h7E41, "R7");
        apply(2'b00, 3'b000, 3'd1, 16'h5A5A, "R2");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule